// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This block compares the CPU instruction fetch address against four programmable 24-bit breakpoint addresses. When an enabled address is fetched, it requests a debug break. The debug port programs the unit through a write-only byte register space. Each breakpoint address is loaded one byte at a time. A single control register holds the per-breakpoint enables and a sticky break flag.

A break is only ever taken on an instruction boundary. If the match hits the first byte of an instruction, the break flag is set on the next clock edge. If the match hits a later byte of a multibyte instruction, the unit records a pending break. That pending break turns into a real break when the CPU signals that the instruction is complete. Once set, the break flag holds the break request high. It stays set until the debugger writes the flag back to zero.

Top module: `brk_unit`

## Requirements
- R1: Reset (rst_n low, asynchronous) forces break_req to 0, clears all enables and the pending state, so no fetch breaks until an enable is written.
- R2: Breakpoint set x (x = 0..3) is loaded at write addresses 4x+0 (bits 7:0), 4x+1 (bits 15:8) and 4x+2 (bits 23:16); the compare value is {byte at 4x+2, byte at 4x+1, byte at 4x+0}.
- R3: A write to address 10h loads the control register: bit 4+x enables set x and bit 0 is the break flag; a disabled set never causes a break.
- R4: An enabled match with fetch_valid=1 and insn_start=1 raises break_req on the following clock edge.
- R5: An enabled match with insn_start=0 and insn_end=0 records a pending break, and break_req rises on the edge after the next insn_end=1 cycle; a match with insn_start=0 and insn_end=1 raises break_req on the next edge directly.
- R6: With fetch_valid=0 no comparison produces a match.
- R7: break_req stays 1 until a write to 10h with bit 0 = 0 clears it on that write's edge; a write to 10h with bit 0 = 1 sets it.
- R8: When a write clears bit 0 in the same cycle as a break-setting event (a boundary match or a pending break meeting insn_end), break_req stays 1.
- R9: Writes to addresses other than 00h-02h, 04h-06h, 08h-0Ah, 0Ch-0Eh and 10h change no state.
- R10: A match requires all 24 address bits to be equal; an address that differs in any one byte does not break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| fetch_valid | input | 1 | fetch_addr carries a valid instruction fetch |
| fetch_addr | input | 24 | CPU instruction fetch address |
| insn_start | input | 1 | The fetched byte is the first byte of an instruction |
| insn_end | input | 1 | The current instruction completes this cycle |
| break_req | output | 1 | Registered break request, equal to the sticky break flag |

## Verification
The bench hits a breakpoint in the middle of an instruction and checks that nothing happens until insn_end. A unit without deferral would break early, and one that lost the pending state would never break. It checks that a clear and a new break event in the same cycle leave the request high; wrong priority would silently drop a breakpoint. Writes to holes in the address map, such as 03h, 07h and 11h, are followed by fetches that must still hit or miss as before; a loose decoder would corrupt an upper byte or set the flag. Near-miss addresses differing in a single byte, and fetches without fetch_valid, catch comparators that are too narrow or ungated.

// File: rtl/brk_pkg.sv
package brk_pkg;

    localparam int DEF_SETS   = 4;
    localparam int DEF_ADDR_W = 24;
    localparam int DEF_BYTE_W = 8;
    localparam int DEF_REG_AW = 8;
    localparam int SET_STRIDE = 4;
    localparam int CTL_ADDR   = 16;
    localparam int ENA_LSB    = 4;
    localparam int NEXT_BIT   = 0;

    typedef struct packed {
        logic pending;
        logic brk_next;
    } brk_state_t;

endpackage

// File: rtl/brk_regfile.sv
module brk_regfile
    import brk_pkg::*;
#(
    parameter int NUM_SETS = DEF_SETS,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int BYTE_W   = DEF_BYTE_W,
    parameter int REG_AW   = DEF_REG_AW
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [REG_AW-1:0]                wr_addr,
    input  logic [BYTE_W-1:0]                wr_data,
    output logic [NUM_SETS-1:0][ADDR_W-1:0]  cmp_addr,
    output logic [NUM_SETS-1:0]              set_en,
    output logic                             ctl_wr,
    output logic                             ctl_next
);

    localparam int BYTES_PER_SET = ADDR_W / BYTE_W;
    localparam logic [REG_AW-1:0] CTL_A = REG_AW'(CTL_ADDR);

    typedef struct packed {
        logic [NUM_SETS-1:0][ADDR_W-1:0] addr;
        logic [NUM_SETS-1:0]             en;
    } rf_t;

    rf_t rf_d, rf_q;
    logic ctl_hit;

    always_comb begin
        rf_d    = rf_q;
        ctl_hit = wr_en && (wr_addr == CTL_A);
        for (int s = 0; s < NUM_SETS; s++) begin
            for (int b = 0; b < BYTES_PER_SET; b++) begin
                if (wr_en && (wr_addr == REG_AW'(s * SET_STRIDE + b))) begin
                    rf_d.addr[s][b*BYTE_W +: BYTE_W] = wr_data;
                end
            end
        end
        if (ctl_hit) begin
            rf_d.en = wr_data[ENA_LSB +: NUM_SETS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign cmp_addr = rf_q.addr;
    assign set_en   = rf_q.en;
    assign ctl_wr   = ctl_hit;
    assign ctl_next = wr_data[NEXT_BIT];

endmodule

// File: rtl/brk_cmp.sv
module brk_cmp
    import brk_pkg::*;
#(
    parameter int NUM_SETS = DEF_SETS,
    parameter int ADDR_W   = DEF_ADDR_W
) (
    input  logic                             fetch_valid,
    input  logic [ADDR_W-1:0]                fetch_addr,
    input  logic [NUM_SETS-1:0][ADDR_W-1:0]  cmp_addr,
    input  logic [NUM_SETS-1:0]              set_en,
    output logic [NUM_SETS-1:0]              hit,
    output logic                             any_hit
);

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic eq;
        assign eq     = (fetch_addr == cmp_addr[s]);
        assign hit[s] = fetch_valid && set_en[s] && eq;
    end

    assign any_hit = |hit;

endmodule

// File: rtl/brk_ctl.sv
module brk_ctl
    import brk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_hit,
    input  logic insn_start,
    input  logic insn_end,
    input  logic ctl_wr,
    input  logic ctl_next,
    output logic pending,
    output logic break_req
);

    brk_state_t st_d, st_q;
    logic set_now;
    logic defer;
    logic convert;

    always_comb begin
        st_d    = st_q;
        set_now = any_hit && (insn_start || insn_end);
        defer   = any_hit && !insn_start && !insn_end;
        convert = st_q.pending && insn_end;

        if (defer) begin
            st_d.pending = 1'b1;
        end else if (insn_end) begin
            st_d.pending = 1'b0;
        end

        if (set_now || convert) begin
            st_d.brk_next = 1'b1;
        end else if (ctl_wr) begin
            st_d.brk_next = ctl_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending   = st_q.pending;
    assign break_req = st_q.brk_next;

endmodule

// File: rtl/brk_unit.sv
module brk_unit
    import brk_pkg::*;
#(
    parameter int NUM_SETS = DEF_SETS,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int BYTE_W   = DEF_BYTE_W,
    parameter int REG_AW   = DEF_REG_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              insn_start,
    input  logic              insn_end,
    output logic              break_req
);

    logic [NUM_SETS-1:0][ADDR_W-1:0] cmp_addr_w;
    logic [NUM_SETS-1:0]             set_en_w;
    logic [NUM_SETS-1:0]             hit_w;
    logic                            any_hit_w;
    logic                            ctl_wr_w;
    logic                            ctl_next_w;
    logic                            pending_w;

    brk_regfile #(
        .NUM_SETS (NUM_SETS),
        .ADDR_W   (ADDR_W),
        .BYTE_W   (BYTE_W),
        .REG_AW   (REG_AW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cmp_addr (cmp_addr_w),
        .set_en   (set_en_w),
        .ctl_wr   (ctl_wr_w),
        .ctl_next (ctl_next_w)
    );

    brk_cmp #(
        .NUM_SETS (NUM_SETS),
        .ADDR_W   (ADDR_W)
    ) u_cmp (
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .cmp_addr    (cmp_addr_w),
        .set_en      (set_en_w),
        .hit         (hit_w),
        .any_hit     (any_hit_w)
    );

    brk_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_hit    (any_hit_w),
        .insn_start (insn_start),
        .insn_end   (insn_end),
        .ctl_wr     (ctl_wr_w),
        .ctl_next   (ctl_next_w),
        .pending    (pending_w),
        .break_req  (break_req)
    );

endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk
    import brk_pkg::*;
#(
    parameter int NUM_SETS = DEF_SETS,
    parameter int REG_AW   = DEF_REG_AW
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [REG_AW-1:0]   wr_addr,
    input logic                wr_bit0,
    input logic                fetch_valid,
    input logic                insn_start,
    input logic                insn_end,
    input logic [NUM_SETS-1:0] hit,
    input logic [NUM_SETS-1:0] set_en,
    input logic                pending,
    input logic                break_req
);

    logic ctl_w;
    assign ctl_w = wr_en && (wr_addr == REG_AW'(CTL_ADDR));

    // R3
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit & ~set_en) == '0);

    // R6
    valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> (hit == '0));

    // R4
    start_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit && insn_start) |=> break_req);

    // R5
    defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit && !insn_start && !insn_end) |=> pending);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (break_req && !(ctl_w && !wr_bit0)) |=> break_req);

    // R5
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(break_req) |-> $past((|hit && (insn_start || insn_end))
                                   || (pending && insn_end)
                                   || (ctl_w && wr_bit0)));

    // R8
    prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && insn_end && ctl_w && !wr_bit0) |=> break_req);

endmodule

bind brk_unit brk_unit_chk #(
    .NUM_SETS (NUM_SETS),
    .REG_AW   (REG_AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_bit0     (wr_data[0]),
    .fetch_valid (fetch_valid),
    .insn_start  (insn_start),
    .insn_end    (insn_end),
    .hit         (hit_w),
    .set_en      (set_en_w),
    .pending     (pending_w),
    .break_req   (break_req)
);

// File: tb/brk_unit_bench.sv
`timescale 1ns/1ps
module brk_unit_bench;

    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        fetch_valid = 1'b0;
    logic [23:0] fetch_addr = '0;
    logic        insn_start = 1'b0;
    logic        insn_end = 1'b0;
    logic        break_req;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(HALF) clk = ~clk;

    brk_unit u_brk_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .insn_start(insn_start), .insn_end(insn_end), .break_req(break_req)
    );

    // vector: [48:45] req, [44] we, [43:36] wa, [35:28] wd, [27] fv,
    //         [26:3] fa, [2] start, [1] end, [0] expected break_req
    function automatic logic [48:0] v(input logic [3:0] rq, input logic we,
        input logic [7:0] wa, input logic [7:0] wd, input logic fv,
        input logic [23:0] fa, input logic st, input logic en, input logic ex);
        return {rq, we, wa, wd, fv, fa, st, en, ex};
    endfunction

    localparam int NV = 37;
    localparam logic [48:0] VEC [NV] = '{
        v(2, 1, 8'h0C, 8'h56, 0, 24'h0,      0, 0, 0), // R2 set3 low
        v(2, 1, 8'h0D, 8'h34, 0, 24'h0,      0, 0, 0), // R2 set3 high
        v(2, 1, 8'h0E, 8'h12, 0, 24'h0,      0, 0, 0), // R2 set3 upper
        v(2, 1, 8'h04, 8'hEF, 0, 24'h0,      0, 0, 0), // R2 set1
        v(2, 1, 8'h05, 8'hCD, 0, 24'h0,      0, 0, 0), // R2
        v(2, 1, 8'h06, 8'hAB, 0, 24'h0,      0, 0, 0), // R2
        v(1, 0, 8'h00, 8'h00, 1, 24'h123456, 1, 0, 0), // R1 nothing enabled
        v(3, 1, 8'h10, 8'h80, 0, 24'h0,      0, 0, 0), // R3 enable set3
        v(4, 0, 8'h00, 8'h00, 1, 24'h123456, 1, 0, 1), // R4 boundary match
        v(7, 0, 8'h00, 8'h00, 0, 24'h0,      0, 0, 1), // R7 hold
        v(7, 0, 8'h00, 8'h00, 1, 24'h000000, 1, 0, 1), // R7 hold
        v(7, 1, 8'h10, 8'h80, 0, 24'h0,      0, 0, 0), // R7 clear
        v(5, 0, 8'h00, 8'h00, 1, 24'h123456, 0, 0, 0), // R5 mid-insn match
        v(5, 0, 8'h00, 8'h00, 1, 24'h123457, 0, 0, 0), // R5 still deferred
        v(5, 0, 8'h00, 8'h00, 1, 24'h123458, 0, 1, 1), // R5 converts at end
        v(7, 1, 8'h10, 8'h80, 0, 24'h0,      0, 0, 0), // R7 clear
        v(6, 0, 8'h00, 8'h00, 0, 24'h123456, 1, 0, 0), // R6 not valid
        v(10, 0, 8'h00, 8'h00, 1, 24'h123457, 1, 0, 0), // R10 low byte off
        v(10, 0, 8'h00, 8'h00, 1, 24'h003456, 1, 0, 0), // R10 upper off
        v(10, 0, 8'h00, 8'h00, 1, 24'h123556, 1, 0, 0), // R10 high off
        v(3, 1, 8'h10, 8'h20, 0, 24'h0,      0, 0, 0), // R3 set1 only
        v(2, 0, 8'h00, 8'h00, 1, 24'hABCDEF, 1, 0, 1), // R2 set1 hit
        v(8, 1, 8'h10, 8'h20, 1, 24'hABCDEF, 1, 0, 1), // R8 clear vs hit
        v(7, 1, 8'h10, 8'h20, 0, 24'h0,      0, 0, 0), // R7 clear
        v(3, 0, 8'h00, 8'h00, 1, 24'h123456, 1, 0, 0), // R3 set3 disabled
        v(9, 1, 8'h03, 8'hFF, 0, 24'h0,      0, 0, 0), // R9 hole
        v(9, 1, 8'h07, 8'h00, 0, 24'h0,      0, 0, 0), // R9 hole
        v(9, 1, 8'h11, 8'hF1, 0, 24'h0,      0, 0, 0), // R9 hole near ctl
        v(9, 0, 8'h00, 8'h00, 1, 24'hABCDEF, 1, 0, 1), // R9 set1 intact
        v(7, 1, 8'h10, 8'h00, 0, 24'h0,      0, 0, 0), // R7 clear
        v(7, 1, 8'h10, 8'h01, 0, 24'h0,      0, 0, 1), // R7 software set
        v(7, 1, 8'h10, 8'h80, 0, 24'h0,      0, 0, 0), // R7 clear
        v(5, 0, 8'h00, 8'h00, 1, 24'h123456, 0, 1, 1), // R5 match at end
        v(7, 1, 8'h10, 8'h80, 0, 24'h0,      0, 0, 0), // R7 clear
        v(5, 0, 8'h00, 8'h00, 1, 24'h123456, 0, 0, 0), // R5 deferred
        v(8, 1, 8'h10, 8'h80, 1, 24'h123459, 0, 1, 1), // R8 clear vs convert
        v(7, 1, 8'h10, 8'h80, 0, 24'h0,      0, 0, 0)  // R7 clear
    };

    task automatic check(input int rq, input logic exp, input string what);
        tests++;
        if (break_req !== exp) begin
            fails++;
            $display("FAIL R%0d %s: break_req=%b expected %b", rq, what, break_req, exp);
        end
    endtask

    task automatic step(input logic we, input logic [7:0] wa, input logic [7:0] wd,
                        input logic fv, input logic [23:0] fa, input logic st,
                        input logic en);
        wr_en = we; wr_addr = wa; wr_data = wd;
        fetch_valid = fv; fetch_addr = fa; insn_start = st; insn_end = en;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1, 1'b0, "in reset");          // R1
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 1'b0, "after reset");       // R1

        for (int i = 0; i < NV; i++) begin
            logic [48:0] e;
            e = VEC[i];
            step(e[44], e[43:36], e[35:28], e[27], e[26:3], e[2], e[1]);
            check(int'(e[48:45]), e[0], $sformatf("vector %0d", i));
        end

        // R2 set0 and set2 byte order
        step(1, 8'h00, 8'hBA, 0, 0, 0, 0);
        step(1, 8'h01, 8'hDC, 0, 0, 0, 0);
        step(1, 8'h02, 8'hFE, 0, 0, 0, 0);
        step(1, 8'h10, 8'h10, 0, 0, 0, 0);
        step(0, 8'h00, 8'h00, 1, 24'hBADCFE, 1, 0);
        check(2, 1'b0, "set0 reversed bytes");
        step(0, 8'h00, 8'h00, 1, 24'hFEDCBA, 1, 0);
        check(2, 1'b1, "set0 hit");
        step(1, 8'h08, 8'h5A, 0, 0, 0, 0);
        step(1, 8'h09, 8'hA5, 0, 0, 0, 0);
        step(1, 8'h0A, 8'h3C, 0, 0, 0, 0);
        step(1, 8'h10, 8'h40, 0, 0, 0, 0);
        check(7, 1'b0, "clear with set2 enable");
        step(0, 8'h00, 8'h00, 1, 24'h3CA55A, 1, 0);
        check(2, 1'b1, "set2 hit");

        // R1 mid-run reset drops break and enables
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 1'b0, "break cleared by reset");
        rst_n = 1'b1;
        @(negedge clk);
        step(0, 8'h00, 8'h00, 1, 24'h3CA55A, 1, 0);
        check(1, 1'b0, "enables cleared by reset");

        step(0, 8'h00, 8'h00, 0, 0, 0, 0);
        summary();
    end

endmodule